// File: doc/BRIEF.md
# Round-Robin Actor Firing Scheduler

This block lets a set of dataflow actors take turns on one shared execution resource. Each actor reports two conditions to the scheduler: whether enough tokens are waiting on its inputs, and whether its outputs can accept results. The scheduler walks a visiting sequence that is fixed when the block is built. When the actor under the pointer meets both conditions, the scheduler sends it a single-cycle fire strobe. It then waits for that actor's done pulse before it moves on. An actor that does not meet both conditions is passed over in one cycle. The walk wraps around and never ends.

Eligibility is decided while the block runs, from the live condition inputs. The visiting sequence is not a precomputed firing schedule, because the block can skip any slot in it. At most one actor runs at a time. A firing that has started cannot be cut short. Changes to the condition inputs while it runs have no effect, and only the running actor's own done pulse ends it. The visiting sequence is the parameter `VISIT_ORDER`. Slot k holds an actor number in bits `[k*IDX_W +: IDX_W]`, where `IDX_W = $clog2(N_ACTORS)`. Slot 0 is visited first.

Top module: `actor_sched_rr`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `fire_out` is all zero, `busy_out` is 0 and `cur_idx_out` holds the actor number stored in slot 0 of `VISIT_ORDER`.
- R2: `cur_idx_out` steps through the actor numbers of slots 0, 1, …, N_ACTORS-1 of `VISIT_ORDER` in that order. After the last slot it returns to slot 0 and repeats without end.
- R3: An actor is fired only when its bits in `ready_in` and `room_in` are both 1 at the clock edge where it is polled. Its bit of `fire_out` is then high for exactly the next cycle. At most one bit of `fire_out` is ever high.
- R4: When the polled actor does not have both bits set, `cur_idx_out` moves to the next slot's actor at that same edge. No fire is issued and no extra cycle is spent.
- R5: Once fired, an actor stays current and `busy_out` stays 1 until its own done bit is sampled high. Changes to `ready_in` and `room_in` during that time do not shorten or alter the firing.
- R6: Done bits of actors other than the running one are ignored. So are all done bits while no actor is running.
- R7: At the edge where the running actor's done bit is 1, the pointer moves to the next slot and `busy_out` falls. A done bit that is high during the fire cycle itself is accepted.
- R8: `busy_out` is 1 from the cycle in which the fire strobe is high through the cycle in which the done bit is sampled.
- R9: When no actor is eligible, the scheduler keeps polling and advances one slot every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready_in | input | N_ACTORS | Per actor: enough input tokens are present |
| room_in | input | N_ACTORS | Per actor: output space is free |
| done_in | input | N_ACTORS | Per actor: the current firing has finished |
| fire_out | output | N_ACTORS | One-cycle, one-hot start strobe |
| busy_out | output | 1 | An actor is firing |
| cur_idx_out | output | IDX_W | Number of the actor currently polled or running |

## Verification
Two events can coincide: the start of a firing and its completion. They fall in the same cycle when an actor answers its fire strobe with done in that same cycle. The bench provokes this with zero-latency actors, and with stray done pulses from other actors while one actor is running. A reference model with its own integer pointer and queue-free state predicts `fire_out`, `busy_out` and `cur_idx_out` at every clock. A correct result is one fire strobe, one busy cycle, and the pointer advancing on the very next edge. A second strobe, or a stall, counts as a miscompare.

// File: rtl/rr_sched_pkg.sv
package rr_sched_pkg;
  typedef enum logic {
    ST_POLL = 1'b0,
    ST_RUN  = 1'b1
  } sched_state_e;
endpackage

// File: rtl/rr_order_map.sv
module rr_order_map #(
  parameter int N_ACTORS = 4,
  parameter int IDX_W    = 2,
  parameter logic [N_ACTORS*IDX_W-1:0] VISIT_ORDER = '0
) (
  input  logic [IDX_W-1:0] slot_in,
  output logic [IDX_W-1:0] actor_out
);
  logic [IDX_W-1:0] lut [N_ACTORS];

  for (genvar g = 0; g < N_ACTORS; g++) begin : g_lut
    assign lut[g] = VISIT_ORDER[g*IDX_W +: IDX_W];
  end

  assign actor_out = lut[slot_in];
endmodule

// File: rtl/rr_slot_ptr.sv
module rr_slot_ptr #(
  parameter int N_ACTORS = 4,
  parameter int IDX_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [IDX_W-1:0] slot_q,
  output logic [IDX_W-1:0] slot_nxt
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(N_ACTORS - 1);

  assign slot_nxt = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)          slot_q <= '0;
    else if (advance) slot_q <= slot_nxt;
  end
endmodule

// File: rtl/rr_elig_sel.sv
module rr_elig_sel #(
  parameter int N_ACTORS = 4,
  parameter int IDX_W    = 2
) (
  input  logic [N_ACTORS-1:0] ready_in,
  input  logic [N_ACTORS-1:0] room_in,
  input  logic [N_ACTORS-1:0] done_in,
  input  logic [IDX_W-1:0]    actor_in,
  output logic                can_fire,
  output logic                done_hit
);
  assign can_fire = ready_in[actor_in] & room_in[actor_in];
  assign done_hit = done_in[actor_in];
endmodule

// File: rtl/rr_fire_dec.sv
module rr_fire_dec #(
  parameter int N_ACTORS = 4,
  parameter int IDX_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                launch,
  input  logic [IDX_W-1:0]    actor_in,
  output logic [N_ACTORS-1:0] fire_q
);
  for (genvar g = 0; g < N_ACTORS; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) fire_q[g] <= 1'b0;
      else     fire_q[g] <= launch && (actor_in == IDX_W'(g));
    end
  end
endmodule

// File: rtl/actor_sched_rr.sv
module actor_sched_rr #(
  parameter int N_ACTORS = 4,
  parameter logic [N_ACTORS*((N_ACTORS > 1) ? $clog2(N_ACTORS) : 1)-1:0] VISIT_ORDER = 'hE4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_ACTORS-1:0] ready_in,
  input  logic [N_ACTORS-1:0] room_in,
  input  logic [N_ACTORS-1:0] done_in,
  output logic [N_ACTORS-1:0] fire_out,
  output logic                busy_out,
  output logic [((N_ACTORS > 1) ? $clog2(N_ACTORS) : 1)-1:0] cur_idx_out
);
  import rr_sched_pkg::*;

  localparam int IDX_W = (N_ACTORS > 1) ? $clog2(N_ACTORS) : 1;
  localparam logic [IDX_W-1:0] FIRST_ACTOR = VISIT_ORDER[IDX_W-1:0];

  sched_state_e     state_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] slot_q;
  logic [IDX_W-1:0] slot_nxt;
  logic [IDX_W-1:0] nxt_actor;
  logic             can_fire;
  logic             done_hit;
  logic             launch;
  logic             advance;

  assign launch  = (state_q == ST_POLL) && can_fire;
  assign advance = ((state_q == ST_POLL) && !can_fire) ||
                   ((state_q == ST_RUN)  && done_hit);

  rr_slot_ptr #(.N_ACTORS(N_ACTORS), .IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst(rst), .advance(advance),
    .slot_q(slot_q), .slot_nxt(slot_nxt)
  );

  rr_order_map #(.N_ACTORS(N_ACTORS), .IDX_W(IDX_W), .VISIT_ORDER(VISIT_ORDER)) u_map (
    .slot_in(slot_nxt), .actor_out(nxt_actor)
  );

  rr_elig_sel #(.N_ACTORS(N_ACTORS), .IDX_W(IDX_W)) u_elig (
    .ready_in(ready_in), .room_in(room_in), .done_in(done_in),
    .actor_in(idx_q), .can_fire(can_fire), .done_hit(done_hit)
  );

  rr_fire_dec #(.N_ACTORS(N_ACTORS), .IDX_W(IDX_W)) u_fire (
    .clk(clk), .rst(rst), .launch(launch), .actor_in(idx_q), .fire_q(fire_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_POLL;
      idx_q   <= FIRST_ACTOR;
    end else begin
      if (launch)                                 state_q <= ST_RUN;
      else if ((state_q == ST_RUN) && done_hit)   state_q <= ST_POLL;
      if (advance) idx_q <= nxt_actor;
    end
  end

  assign busy_out    = (state_q == ST_RUN);
  assign cur_idx_out = idx_q;
endmodule

// File: rtl/rr_sched_chk.sv
module rr_sched_chk #(
  parameter int N_ACTORS = 4,
  parameter int IDX_W    = 2
) (
  input logic                clk,
  input logic                rst,
  input logic [N_ACTORS-1:0] ready_in,
  input logic [N_ACTORS-1:0] room_in,
  input logic [N_ACTORS-1:0] done_in,
  input logic [N_ACTORS-1:0] fire_out,
  input logic                busy_out,
  input logic [IDX_W-1:0]    cur_idx_out
);
  p_fire_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fire_out));

  p_fire_single_r3: assert property (@(posedge clk) disable iff (rst)
    (|fire_out) |=> !(|fire_out));

  p_fire_eligible_r3: assert property (@(posedge clk) disable iff (rst)
    (|fire_out) |-> (($past(ready_in & room_in) & fire_out) == fire_out));

  p_fire_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (|fire_out) |-> busy_out);

  p_hold_run_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_out && !done_in[cur_idx_out]) |=> (busy_out && $stable(cur_idx_out)));

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_out && done_in[cur_idx_out]) |=> !busy_out);

  if (N_ACTORS > 1) begin : g_skip
    p_skip_advance_r4: assert property (@(posedge clk) disable iff (rst)
      (!busy_out && !(ready_in[cur_idx_out] && room_in[cur_idx_out]))
        |=> (!busy_out && (cur_idx_out != $past(cur_idx_out))));
  end
endmodule

bind actor_sched_rr rr_sched_chk #(.N_ACTORS(N_ACTORS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .ready_in(ready_in), .room_in(room_in),
  .done_in(done_in), .fire_out(fire_out), .busy_out(busy_out),
  .cur_idx_out(cur_idx_out)
);

// File: tb/actor_sched_rr_tb.sv
module actor_sched_rr_tb;
  localparam int N = 4;
  localparam int W = 2;
  // slot0 = actor3, slot1 = actor1, slot2 = actor0, slot3 = actor2
  localparam logic [N*W-1:0] ORDER = 8'h87;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] ready_in = '0;
  logic [N-1:0] room_in  = '0;
  logic [N-1:0] done_in;
  logic [N-1:0] fire_out;
  logic         busy_out;
  logic [W-1:0] cur_idx_out;

  int vectors = 0;
  int miscompares = 0;
  string phase = "R1";

  int ord [N] = '{3, 1, 0, 2};
  int lat [N] = '{1, 1, 1, 1};
  int cnt [N] = '{0, 0, 0, 0};
  bit act [N] = '{0, 0, 0, 0};
  logic [N-1:0] actor_done = '0;
  logic [N-1:0] stray = '0;

  int  m_slot = 0;
  bit  m_run  = 0;
  int  m_fire = 0;
  bit  started = 0;

  always #5 clk = ~clk;

  actor_sched_rr #(.N_ACTORS(N), .VISIT_ORDER(ORDER)) u_dut (
    .clk(clk), .rst(rst), .ready_in(ready_in), .room_in(room_in),
    .done_in(done_in), .fire_out(fire_out), .busy_out(busy_out),
    .cur_idx_out(cur_idx_out)
  );

  assign done_in = actor_done | stray;

  // Reference model
  always @(posedge clk) begin
    if (rst) begin
      m_slot = 0; m_run = 0; m_fire = 0;
    end else if (!m_run) begin
      int a;
      a = ord[m_slot];
      if (ready_in[a] && room_in[a]) begin
        m_run = 1; m_fire = 1 << a;
      end else begin
        m_fire = 0; m_slot = (m_slot + 1) % N;
      end
    end else begin
      m_fire = 0;
      if (done_in[ord[m_slot]]) begin
        m_run = 0; m_slot = (m_slot + 1) % N;
      end
    end
  end

  // Actor responders
  always @(negedge clk) begin
    logic [N-1:0] d;
    d = '0;
    for (int a = 0; a < N; a++) begin
      if (fire_out[a]) begin act[a] = 1; cnt[a] = lat[a]; end
      if (act[a]) begin
        if (cnt[a] == 0) begin d[a] = 1'b1; act[a] = 0; end
        else cnt[a] = cnt[a] - 1;
      end
    end
    actor_done <= d;
  end

  // Per-cycle comparison
  always @(negedge clk) begin
    if (started && !rst) begin
      vectors++;
      if (fire_out !== N'(m_fire)) begin
        miscompares++;
        $display("FAIL %s fire_out actual=%b expected=%b", phase, fire_out, N'(m_fire));
      end
      if (busy_out !== m_run) begin
        miscompares++;
        $display("FAIL %s R8 busy_out actual=%b expected=%b", phase, busy_out, m_run);
      end
      if (cur_idx_out !== W'(ord[m_slot])) begin
        miscompares++;
        $display("FAIL %s R2 cur_idx_out actual=%0d expected=%0d", phase, cur_idx_out, ord[m_slot]);
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    cycles(2);
    // R1: state right after a reset edge
    vectors++;
    if (fire_out !== '0 || busy_out !== 1'b0 || cur_idx_out !== 2'd3) begin
      miscompares++;
      $display("FAIL R1 reset actual fire=%b busy=%b idx=%0d expected fire=0000 busy=0 idx=3",
               fire_out, busy_out, cur_idx_out);
    end
    rst = 1'b0;
    started = 1;

    phase = "R9"; // nothing eligible: pointer circulates
    cycles(12);

    phase = "R3"; // tokens present but no room, then room but no tokens
    ready_in = '1; room_in = '0;
    cycles(8);
    ready_in = '0; room_in = '1;
    cycles(8);
    lat = '{2, 2, 2, 2};
    ready_in = 4'b0001; room_in = 4'b0001;
    cycles(12);

    phase = "R2 R8"; // all eligible, full rotation in slot order
    lat = '{1, 2, 0, 3};
    ready_in = '1; room_in = '1;
    cycles(40);

    phase = "R5"; // conditions drop while actor 1 runs
    ready_in = '0;
    cycles(6);
    lat = '{1, 6, 1, 1};
    ready_in = 4'b0010;
    for (int k = 0; k < 20 && !fire_out[1]; k++) @(negedge clk);
    ready_in = '0; room_in = '0;
    cycles(12);

    phase = "R6"; // stray done from others while actor 2 runs, and while idle
    room_in = '1;
    stray = 4'b1011;
    lat = '{1, 1, 5, 1};
    ready_in = 4'b0100;
    cycles(24);
    ready_in = '0;
    stray = '1;
    cycles(8);
    stray = '0;

    phase = "R7"; // done in the fire cycle
    lat = '{0, 0, 0, 0};
    ready_in = '1;
    cycles(20);

    phase = "R4"; // only actor 0 eligible: others skipped in one cycle each
    ready_in = 4'b0001;
    cycles(20);
    ready_in = 4'b1010; room_in = 4'b0110;
    cycles(16);

    phase = "R1";
    rst = 1'b1;
    cycles(2);
    vectors++;
    if (fire_out !== '0 || busy_out !== 1'b0 || cur_idx_out !== 2'd3) begin
      miscompares++;
      $display("FAIL R1 re-reset actual fire=%b busy=%b idx=%0d expected fire=0000 busy=0 idx=3",
               fire_out, busy_out, cur_idx_out);
    end
    rst = 1'b0;
    cycles(4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule